// File: doc/BRIEF.md
# Two-Channel Timer Output-Compare Unit

This block turns a running timer count into two reference waveforms and one combined waveform. Each channel compares the shared count against its own compare value. A 4-bit mode field per channel selects how the comparison drives that channel's reference. The channel can hold the reference, act on an exact match, force a fixed level, produce edge-style PWM, or produce a one-pulse window. That window opens on an external trigger and closes on the timer update event. The counter, dead-time insertion and output enables sit outside the block.

The combined output belongs to channel 1. Its mode field picks how the two channel references merge: OR, AND, or a selection by count direction that yields asymmetric waveforms. In every other channel-1 mode the combined output simply copies the channel-1 reference. All outputs are registered, so a change of mode or compare value cannot glitch an output.

Top module: `oc_unit`

## Requirements
- R1: While rst_ni is low, ref1_o, ref2_o and comb_o are 0. The one-pulse windows of both channels are closed.
- R2: Mode code 0 (hold) and the unused codes 14 and 15 keep the reference at its previous value, whatever the count, compare, trigger and update inputs do.
- R3: Code 1 sets the reference to 1 in a cycle where cnt_i equals the compare value, and code 2 clears it to 0 in such a cycle. In both modes the reference holds when there is no match.
- R4: Code 3 inverts the reference in each cycle where cnt_i equals the compare value, and holds it otherwise.
- R5: Code 5 drives the reference to 1 and code 4 drives it to 0, regardless of count and compare.
- R6: Code 6 (PWM A) makes the reference 1 exactly when cnt_i is below the compare value. Code 7 (PWM B) gives the complement.
- R7: Code 8 (one-pulse A) behaves as follows. With the window closed, the reference is 1 when counting up (dir_down_i=0) and 0 when counting down. With the window open, it follows the PWM A rule. A trigger opens the window. An update without a trigger closes it, and the reference takes its idle level at that same edge.
- R8: Code 9 (one-pulse B) uses the same window. Its closed-window level is 0 counting up and 1 counting down. With the window open it follows the PWM B rule.
- R9: A trigger while the window is open keeps it open and restarts it. When trigger and update arrive in the same cycle, the trigger wins and the window stays open.
- R10: With mode1_i at code 10 (combined A), comb_o is ref1_o OR ref2_o. With code 11 (combined B), comb_o is ref1_o AND ref2_o. In both cases channel 1 follows PWM A or PWM B respectively. A channel given code 10 or 11, 12 or 13 drives its own reference by PWM A or PWM B.
- R11: With mode1_i at code 12 or 13 (asymmetric A/B), comb_o equals ref1_o while counting up and ref2_o while counting down. Channel 1 follows PWM A for code 12 and PWM B for code 13.
- R12: For channel-1 codes other than 10 to 13, comb_o equals ref1_o. Every output reflects the inputs sampled at the previous rising clock edge, so a mode change takes effect on the cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current timer count |
| dir_down_i | input | 1 | 1 while the timer counts down |
| upd_i | input | 1 | Timer update event, one cycle |
| trig_i | input | 1 | External trigger, one cycle |
| cmp1_i | input | CNT_W | Channel 1 compare value |
| cmp2_i | input | CNT_W | Channel 2 compare value |
| mode1_i | input | 4 | Channel 1 mode code |
| mode2_i | input | 4 | Channel 2 mode code |
| ref1_o | output | 1 | Channel 1 reference |
| ref2_o | output | 1 | Channel 2 reference |
| comb_o | output | 1 | Channel 1 combined/asymmetric output |

## Verification
The bench targets several corner cases, and each one has a visible failure mode:

- **Trigger and update in the same cycle.** A design that let the update win would drop the reference to its idle level mid-pulse.
- **Retrigger inside an open window.** A design that ignored it would close the window at the next update without restarting.
- **Direction flip while the window is closed.** The idle level must follow the direction; getting this wrong shows as an inverted idle level.
- **Unused mode codes.** These must hold the reference rather than decode as some active mode.
- **Toggle on consecutive matches.** A design with no match gating would toggle on every cycle.
- **Mode switches while the asymmetric selector changes direction.** A wrong selector shows comb_o tracking the wrong channel.
- **Compare at zero and at the count value.** An off-by-one in the below-compare rule shows at these boundaries.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [3:0] {
    OC_HOLD    = 4'd0,
    OC_SET     = 4'd1,
    OC_CLR     = 4'd2,
    OC_TOG     = 4'd3,
    OC_FORCE0  = 4'd4,
    OC_FORCE1  = 4'd5,
    OC_PWMA    = 4'd6,
    OC_PWMB    = 4'd7,
    OC_OPA     = 4'd8,
    OC_OPB     = 4'd9,
    OC_COMBA   = 4'd10,
    OC_COMBB   = 4'd11,
    OC_ASYMA   = 4'd12,
    OC_ASYMB   = 4'd13,
    OC_RSV14   = 4'd14,
    OC_RSV15   = 4'd15
  } oc_mode_e;

  localparam int unsigned MODE_W = 4;
  localparam int unsigned N_CH   = 2;

  // 1 when the mode uses the "A" (below-compare active) PWM polarity family
  function automatic logic is_pwm_a(oc_mode_e m);
    return (m == OC_PWMA) || (m == OC_COMBA) || (m == OC_ASYMA);
  endfunction

  function automatic logic is_pwm_b(oc_mode_e m);
    return (m == OC_PWMB) || (m == OC_COMBB) || (m == OC_ASYMB);
  endfunction
endpackage

// File: rtl/oc_window.sv
module oc_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic upd_i,
  output logic open_nxt_o,
  output logic open_o
);
  logic open_q;

  // trigger has priority over update: a same-cycle pair restarts the window
  assign open_nxt_o = trig_i | (open_q & ~upd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else         open_q <= open_nxt_o;
  end
  assign open_o = open_q;

  assert_trig_opens_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> open_o);
  assert_upd_closes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !trig_i) |=> !open_o);
  assert_idle_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && !upd_i) |=> open_o == $past(open_o));
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic             dir_down_i,
  input  logic             upd_i,
  input  logic             trig_i,
  output logic             ref_nxt_o,
  output logic             ref_o
);
  oc_mode_e mode;
  logic     ref_q;
  logic     hit;
  logic     below;
  logic     win_nxt;
  logic     win_q;

  assign mode  = oc_mode_e'(mode_i);
  assign hit   = (cnt_i == cmp_i);
  assign below = (cnt_i < cmp_i);

  oc_window u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .upd_i      (upd_i),
    .open_nxt_o (win_nxt),
    .open_o     (win_q)
  );

  always_comb begin
    ref_nxt_o = ref_q;
    if (is_pwm_a(mode)) ref_nxt_o = below;
    else if (is_pwm_b(mode)) ref_nxt_o = ~below;
    else begin
      unique case (mode)
        OC_SET:    if (hit) ref_nxt_o = 1'b1;
        OC_CLR:    if (hit) ref_nxt_o = 1'b0;
        OC_TOG:    if (hit) ref_nxt_o = ~ref_q;
        OC_FORCE0: ref_nxt_o = 1'b0;
        OC_FORCE1: ref_nxt_o = 1'b1;
        OC_OPA:    ref_nxt_o = win_nxt ? below  : ~dir_down_i;
        OC_OPB:    ref_nxt_o = win_nxt ? ~below : dir_down_i;
        default:   ref_nxt_o = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_nxt_o;
  end
  assign ref_o = ref_q;

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd0 || mode_i >= 4'd14) |=> ref_o == $past(ref_o));
  assert_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd3 && cnt_i == cmp_i) |=> ref_o != $past(ref_o));
  assert_force1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd5) |=> ref_o);
  assert_force0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd4) |=> !ref_o);
  assert_pwma_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd6) |=> ref_o == $past(cnt_i < cmp_i));
  assert_opa_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd8 && !win_q && !trig_i) |=> ref_o == !$past(dir_down_i));
endmodule

// File: rtl/oc_combiner.sv
module oc_combiner
  import oc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              dir_down_i,
  input  logic              ref1_nxt_i,
  input  logic              ref2_nxt_i,
  input  logic              ref1_i,
  input  logic              ref2_i,
  output logic              comb_o
);
  oc_mode_e mode;
  logic     comb_nxt;
  logic     comb_q;

  assign mode = oc_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      OC_COMBA:          comb_nxt = ref1_nxt_i | ref2_nxt_i;
      OC_COMBB:          comb_nxt = ref1_nxt_i & ref2_nxt_i;
      OC_ASYMA, OC_ASYMB: comb_nxt = dir_down_i ? ref2_nxt_i : ref1_nxt_i;
      default:           comb_nxt = ref1_nxt_i;
    endcase
  end

  // registered alongside the channel references so all three outputs align
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) comb_q <= 1'b0;
    else         comb_q <= comb_nxt;
  end
  assign comb_o = comb_q;

  assert_comb_or_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd10) |=> comb_o == (ref1_i | ref2_i));
  assert_comb_and_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd11) |=> comb_o == (ref1_i & ref2_i));
  assert_asym_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd12 || mode_i == 4'd13) |=> comb_o == ($past(dir_down_i) ? ref2_i : ref1_i));
  assert_plain_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i < 4'd10 || mode_i > 4'd13) |=> comb_o == ref1_i);
endmodule

// File: rtl/oc_unit.sv
module oc_unit
  import oc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_down_i,
  input  logic             upd_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] cmp1_i,
  input  logic [CNT_W-1:0] cmp2_i,
  input  logic [3:0]       mode1_i,
  input  logic [3:0]       mode2_i,
  output logic             ref1_o,
  output logic             ref2_o,
  output logic             comb_o
);
  logic [CNT_W-1:0]  cmp  [N_CH];
  logic [MODE_W-1:0] mode [N_CH];
  logic [N_CH-1:0]   ref_nxt;
  logic [N_CH-1:0]   ref_q;

  assign cmp[0]  = cmp1_i;
  assign cmp[1]  = cmp2_i;
  assign mode[0] = mode1_i;
  assign mode[1] = mode2_i;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    oc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt_i),
      .cmp_i      (cmp[g]),
      .mode_i     (mode[g]),
      .dir_down_i (dir_down_i),
      .upd_i      (upd_i),
      .trig_i     (trig_i),
      .ref_nxt_o  (ref_nxt[g]),
      .ref_o      (ref_q[g])
    );
  end

  oc_combiner u_comb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode1_i),
    .dir_down_i (dir_down_i),
    .ref1_nxt_i (ref_nxt[0]),
    .ref2_nxt_i (ref_nxt[1]),
    .ref1_i     (ref_q[0]),
    .ref2_i     (ref_q[1]),
    .comb_o     (comb_o)
  );

  assign ref1_o = ref_q[0];
  assign ref2_o = ref_q[1];

  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!ref1_o && !ref2_o && !comb_o));
endmodule

// File: tb/oc_unit_bench.sv
module oc_unit_bench;
  localparam int unsigned CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic             down = 1'b0;
  logic             upd = 1'b0;
  logic             trig = 1'b0;
  logic [CNT_W-1:0] cmp1 = '0;
  logic [CNT_W-1:0] cmp2 = '0;
  logic [3:0]       m1 = '0;
  logic [3:0]       m2 = '0;
  logic             r1, r2, cb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic e1 = 0, e2 = 0, ec = 0, w = 0;

  always #10 clk = ~clk;

  oc_unit #(.CNT_W(CNT_W)) u_oc_unit (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .dir_down_i(down),
    .upd_i(upd), .trig_i(trig), .cmp1_i(cmp1), .cmp2_i(cmp2),
    .mode1_i(m1), .mode2_i(m2), .ref1_o(r1), .ref2_o(r2), .comb_o(cb)
  );

  function automatic logic ref_model(logic [3:0] m, logic r, logic [CNT_W-1:0] c,
                                     logic [CNT_W-1:0] k, logic dn, logic wn);
    logic lt = (c < k);
    case (m)
      4'd1: return (c == k) ? 1'b1 : r;
      4'd2: return (c == k) ? 1'b0 : r;
      4'd3: return (c == k) ? ~r : r;
      4'd4: return 1'b0;
      4'd5: return 1'b1;
      4'd6, 4'd10, 4'd12: return lt;
      4'd7, 4'd11, 4'd13: return ~lt;
      4'd8: return wn ? lt : ~dn;
      4'd9: return wn ? ~lt : dn;
      default: return r;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] m);
    case (m)
      4'd0, 4'd14, 4'd15: return "R2";
      4'd1, 4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      4'd10, 4'd11: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic check3(string tag);
    checks++;
    if (r1 !== e1 || r2 !== e2 || cb !== ec) begin
      errors++;
      $display("FAIL %s: got ref1=%b ref2=%b comb=%b expected ref1=%b ref2=%b comb=%b (m1=%0d m2=%0d)",
               tag, r1, r2, cb, e1, e2, ec, m1, m2);
    end
  endtask

  // drive at negedge, model the posedge, sample 1 ns after it
  task automatic step(string tag, logic [3:0] a, logic [3:0] b, logic [CNT_W-1:0] c,
                      logic [CNT_W-1:0] k1, logic [CNT_W-1:0] k2,
                      logic dn, logic u, logic t);
    logic wn, n1, n2;
    @(negedge clk);
    m1 = a; m2 = b; cnt = c; cmp1 = k1; cmp2 = k2; down = dn; upd = u; trig = t;
    wn = t | (w & ~u);
    n1 = ref_model(a, e1, c, k1, dn, wn);
    n2 = ref_model(b, e2, c, k2, dn, wn);
    case (a)
      4'd10: ec = n1 | n2;
      4'd11: ec = n1 & n2;
      4'd12, 4'd13: ec = dn ? n2 : n1;
      default: ec = n1;
    endcase
    e1 = n1; e2 = n2; w = wn;
    @(posedge clk); #1;
    check3(tag == "" ? tag_of(a) : tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (r1 !== 0 || r2 !== 0 || cb !== 0) begin
      errors++;
      $display("FAIL R1: got %b%b%b expected 000", r1, r2, cb);
    end
    @(negedge clk); rst_n = 1'b1;

    // R5 force, then R2 hold and unused codes keep level
    step("R5", 4'd5, 4'd4, 16'd3, 16'd9, 16'd9, 0, 0, 0);
    step("R2", 4'd14, 4'd15, 16'd9, 16'd9, 16'd9, 0, 1, 1);
    step("R2", 4'd0, 4'd0, 16'd1, 16'd1, 16'd1, 1, 0, 0);
    // R12 mode change takes effect one cycle later
    step("R12", 4'd4, 4'd5, 16'd0, 16'd0, 16'd0, 0, 0, 0);
    // R3 set/clear on match and hold on miss
    step("R3", 4'd1, 4'd2, 16'd5, 16'd5, 16'd5, 0, 0, 0);
    step("R3", 4'd2, 4'd1, 16'd4, 16'd5, 16'd5, 0, 0, 0);
    // R4 toggle on consecutive matches, then hold on miss
    step("R4", 4'd3, 4'd3, 16'd7, 16'd7, 16'd7, 0, 0, 0);
    step("R4", 4'd3, 4'd3, 16'd7, 16'd7, 16'd7, 0, 0, 0);
    step("R4", 4'd3, 4'd3, 16'd6, 16'd7, 16'd7, 0, 0, 0);
    // R6 boundaries: compare 0, equal, below
    step("R6", 4'd6, 4'd7, 16'd0, 16'd0, 16'd0, 0, 0, 0);
    step("R6", 4'd6, 4'd7, 16'd4, 16'd4, 16'd5, 0, 0, 0);
    step("R6", 4'd6, 4'd7, 16'd3, 16'd4, 16'd4, 1, 0, 0);
    // R7/R8 idle levels by direction, trigger, retrigger, end on update
    step("R7", 4'd8, 4'd9, 16'd2, 16'd1, 16'd1, 0, 0, 0);
    step("R8", 4'd8, 4'd9, 16'd2, 16'd1, 16'd1, 1, 0, 0);
    step("R7", 4'd8, 4'd9, 16'd2, 16'd1, 16'd1, 0, 0, 1);
    step("R9", 4'd8, 4'd9, 16'd0, 16'd1, 16'd1, 0, 1, 1);
    step("R9", 4'd8, 4'd9, 16'd0, 16'd1, 16'd1, 0, 0, 1);
    step("R7", 4'd8, 4'd9, 16'd0, 16'd1, 16'd1, 0, 1, 0);
    step("R8", 4'd8, 4'd9, 16'd0, 16'd1, 16'd1, 1, 0, 0);
    // R10 combined, R11 asymmetric with direction flip
    step("R10", 4'd10, 4'd7, 16'd5, 16'd3, 16'd2, 0, 0, 0);
    step("R10", 4'd11, 4'd6, 16'd1, 16'd3, 16'd2, 0, 0, 0);
    step("R11", 4'd12, 4'd7, 16'd1, 16'd3, 16'd2, 0, 0, 0);
    step("R11", 4'd12, 4'd7, 16'd1, 16'd3, 16'd2, 1, 0, 0);
    step("R11", 4'd13, 4'd6, 16'd1, 16'd3, 16'd2, 1, 0, 0);
    step("R12", 4'd6, 4'd5, 16'd9, 16'd3, 16'd2, 1, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a = m1, b = m2;
      if ($urandom_range(0, 7) == 0) a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 7) == 0) b = 4'($urandom_range(0, 15));
      step("", a, b, CNT_W'($urandom_range(0, 7)), CNT_W'($urandom_range(0, 7)),
           CNT_W'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 11) == 0));
    end
    finish_run();
  end
endmodule